// File: doc/BRIEF.md
# Two-Channel Instruction Break Unit

This block watches the in-order stream of instructions leaving a CPU pipeline and raises a debug break request when an executed instruction's address equals an address programmed into one of two comparator channels. Every channel has an address register, a condition register that arms fetch-address matching, and an operation register that enables the request and picks whether the break is taken before the matching instruction runs or after it, ahead of the next one. Fetches that were never executed, such as overrun fetches past a branch or at interrupt entry, are ignored.

Each channel keeps a sticky hit flag. Software clears it by writing 1. The flag is set on every hit, including hits made while the block-interrupt input masks requests. In sequential mode only channel 1 may request, and only once channel 0 has already hit. Delayed branches are handled in two ways. A pre-execution break on a delay slot is moved ahead of the owning branch. A post-execution break on a branch or its slot is held until the first instruction at the branch target.

Top module: `ibrk_unit`

## Requirements
- R1: A channel hits when its condition register bit 0 (fetch select) is 1 and an executed instruction (valid=1, exec=1) arrives whose address equals the channel address register in all bits except bit 0. A hit sets the channel's flag: bit 8 of the status register (index 6) for channel 0, bit 9 for channel 1. The flag stays set until it is cleared.
- R2: A hit raises a request only if bit 0 (enable) of that channel's operation register is 1. With the enable at 0 the flag is still set.
- R3: When operation bit 1 is 0 (pre-execution), `brk_req` pulses for one cycle in the cycle after the matching beat. `brk_chan` then gives the channel and `brk_addr` gives the matching instruction's address.
- R4: When operation bit 1 is 1 (post-execution), the request is held pending. It is issued in the cycle after the next executed instruction that is not a delay slot, and `brk_addr` gives that instruction's address.
- R5: An overrun beat (valid=1, exec=0) never hits, never sets a flag, and never delivers a pending post-execution request.
- R6: A beat with the delayed-branch marker set carries its slot's address on `ins_slot_addr`. A pre-execution match on that slot address requests on the branch beat, with `brk_addr` giving the branch address. The slot beat itself does not request.
- R7: A post-execution match on a delayed branch or on its delay slot is delivered at the first instruction at the branch target.
- R8: While `block_int` is 1 no request is issued, but flags still set. A pending post-execution request whose delivery beat is blocked is dropped.
- R9: With bit 0 of a channel's address register at 1, that channel never hits: no flag and no request.
- R10: With status bit 0 (sequential) at 1, channel 0 never requests. Channel 1 requests only if channel 0's flag was set by an earlier beat. Both flags still set on their own hits.
- R11: Writing 1 to status bit 8 or 9 clears that flag, and status bit 0 takes the written value. Clearing channel 0's flag in sequential mode disarms channel 1.
- R12: If several requests compete on one beat, a pending post-execution request wins over a new pre-execution hit. Between two new hits, channel 0 wins.
- R13: Channel 1's data-compare bit (condition bit 1), its data value register (index 7) and its data mask register (index 8) have no effect on fetch matching.
- R14: All registers read back what was written and read 0 after reset. The indices are 0/1/2 for channel 0 address/condition/operation, 3/4/5 for channel 1, 6 for status, and 7/8 for the data value and mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word index |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| ins_valid | input | 1 | An instruction beat is present |
| ins_addr | input | ADDR_W | Fetch address of the beat |
| ins_exec | input | 1 | 1 = executed, 0 = overrun fetch |
| ins_dbr | input | 1 | Beat is a delayed branch |
| ins_slot | input | 1 | Beat is a delay-slot instruction |
| ins_slot_addr | input | ADDR_W | Slot address, valid with ins_dbr |
| block_int | input | 1 | Masks break requests |
| brk_req | output | 1 | One-cycle break request |
| brk_chan | output | 1 | Channel that caused the request |
| brk_addr | output | ADDR_W | Instruction before which the break is taken |

## Verification
The hardest cases to reach are the ones where a pending post-execution request meets a later beat. The later beat may be an overrun fetch, a delay slot, a blocked instruction, or a fresh pre-execution hit from the other channel. The bench builds each of these from short beat sequences: first a post-matching instruction, then the disturbing beat, then a plain instruction. A scoreboard checks that the request lands on exactly the expected beat with the expected address, or does not land at all. Sequential mode is reached by hitting channel 1 before and after channel 0 hits, and again after software clears channel 0's flag.

// File: rtl/ibrk_pkg.sv
package ibrk_pkg;

   // register word indices
   localparam int unsigned CH_STRIDE = 3;
   localparam int unsigned OFS_ADDR  = 0;
   localparam int unsigned OFS_COND  = 1;
   localparam int unsigned OFS_OP    = 2;
   localparam int unsigned IDX_STAT  = 6;
   localparam int unsigned IDX_DVAL  = 7;
   localparam int unsigned IDX_DMASK = 8;

   // status register bit positions
   localparam int unsigned STAT_SEQ  = 0;
   localparam int unsigned STAT_FLG  = 8;

   localparam int unsigned NUM_CH    = 2;

   typedef struct packed {
      logic fetch_sel;
      logic brk_en;
      logic post_sel;
   } ch_ctl_t;

endpackage

// File: rtl/ibrk_regs.sv
module ibrk_regs
   import ibrk_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned REG_AW = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [REG_AW-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic [NUM_CH-1:0]   match_set,
   output logic [ADDR_W-1:0]   ch_addr [NUM_CH],
   output ch_ctl_t             ch_ctl  [NUM_CH],
   output logic                seq_mode,
   output logic                flag0
);

   localparam int unsigned NREG = IDX_DMASK + 1;

   generate
      if (ADDR_W < 2 || ADDR_W > DATA_W) begin : g_bad_w
         $error("ibrk_regs: ADDR_W must lie in 2..DATA_W");
      end
      if ((1 << REG_AW) < NREG) begin : g_bad_aw
         $error("ibrk_regs: REG_AW too small for register map");
      end
   endgenerate

   logic [NUM_CH-1:0] dcmp_q;
   logic [NUM_CH-1:0] flag_q;
   logic [DATA_W-1:0] dval_q, dmask_q;
   logic              seq_q;
   logic              wr_stat;

   assign wr_stat = reg_we && (reg_addr == REG_AW'(IDX_STAT));

   genvar g;
   generate
      for (g = 0; g < NUM_CH; g++) begin : g_ch
         localparam int unsigned BASE = g * CH_STRIDE;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ch_addr[g] <= '0;
               ch_ctl[g]  <= '0;
               dcmp_q[g]  <= 1'b0;
            end else if (reg_we) begin
               if (reg_addr == REG_AW'(BASE + OFS_ADDR))
                  ch_addr[g] <= reg_wdata[ADDR_W-1:0];
               if (reg_addr == REG_AW'(BASE + OFS_COND)) begin
                  ch_ctl[g].fetch_sel <= reg_wdata[0];
                  dcmp_q[g]           <= reg_wdata[1];
               end
               if (reg_addr == REG_AW'(BASE + OFS_OP)) begin
                  ch_ctl[g].brk_en   <= reg_wdata[0];
                  ch_ctl[g].post_sel <= reg_wdata[1];
               end
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q[g] <= 1'b0;
            else        flag_q[g] <= match_set[g] |
                                     (flag_q[g] & ~(wr_stat & reg_wdata[STAT_FLG + g]));
         end

         AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            flag_q[g] && !(wr_stat && reg_wdata[STAT_FLG + g]) |=> flag_q[g]); // R1
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q   <= 1'b0;
         dval_q  <= '0;
         dmask_q <= '0;
      end else if (reg_we) begin
         if (wr_stat)                            seq_q   <= reg_wdata[STAT_SEQ];
         if (reg_addr == REG_AW'(IDX_DVAL))      dval_q  <= reg_wdata;
         if (reg_addr == REG_AW'(IDX_DMASK))     dmask_q <= reg_wdata;
      end
   end

   always_comb begin
      reg_rdata = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (reg_addr == REG_AW'(c * CH_STRIDE + OFS_ADDR))
            reg_rdata[ADDR_W-1:0] = ch_addr[c];
         if (reg_addr == REG_AW'(c * CH_STRIDE + OFS_COND))
            reg_rdata[1:0] = {dcmp_q[c], ch_ctl[c].fetch_sel};
         if (reg_addr == REG_AW'(c * CH_STRIDE + OFS_OP))
            reg_rdata[1:0] = {ch_ctl[c].post_sel, ch_ctl[c].brk_en};
      end
      if (reg_addr == REG_AW'(IDX_STAT)) begin
         reg_rdata[STAT_SEQ] = seq_q;
         reg_rdata[STAT_FLG +: NUM_CH] = flag_q;
      end
      if (reg_addr == REG_AW'(IDX_DVAL))  reg_rdata = dval_q;
      if (reg_addr == REG_AW'(IDX_DMASK)) reg_rdata = dmask_q;
   end

   assign seq_mode = seq_q;
   assign flag0    = flag_q[0];

   AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stat && reg_wdata[STAT_FLG] && !match_set[0] |=> !flag0); // R11

endmodule

// File: rtl/ibrk_chan.sv
module ibrk_chan
   import ibrk_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] cfg_addr,
   input  ch_ctl_t           cfg_ctl,
   input  logic              ins_valid,
   input  logic              ins_exec,
   input  logic              ins_dbr,
   input  logic              ins_slot,
   input  logic [ADDR_W-1:0] ins_addr,
   input  logic [ADDR_W-1:0] ins_slot_addr,
   output logic              hit,
   output logic              cand_pre,
   output logic              cand_post
);

   localparam logic [ADDR_W-1:0] CMP_MASK = ~ADDR_W'(1);

   logic armed, live, eq_cur, eq_slot;

   assign armed   = cfg_ctl.fetch_sel & ~cfg_addr[0];
   assign live    = ins_valid & ins_exec;
   assign eq_cur  = ((ins_addr      ^ cfg_addr) & CMP_MASK) == '0;
   assign eq_slot = ((ins_slot_addr ^ cfg_addr) & CMP_MASK) == '0;

   assign hit       = live & armed & eq_cur;
   assign cand_pre  = ~cfg_ctl.post_sel &
                      ((hit & ~ins_slot) | (live & ins_dbr & armed & eq_slot));
   assign cand_post = cfg_ctl.post_sel & hit;

endmodule

// File: rtl/ibrk_issue.sv
module ibrk_issue
   import ibrk_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] cand_pre,
   input  logic [NUM_CH-1:0] cand_post,
   input  logic [NUM_CH-1:0] brk_en,
   input  logic              seq_mode,
   input  logic              flag0,
   input  logic              block_int,
   input  logic              ins_valid,
   input  logic              ins_exec,
   input  logic              ins_slot,
   input  logic [ADDR_W-1:0] ins_addr,
   output logic              brk_req,
   output logic              brk_chan,
   output logic [ADDR_W-1:0] brk_addr
);

   logic [NUM_CH-1:0] gate, pre_ok, post_ok;
   logic              pend_v, pend_ch;
   logic              deliver, fire, fire_ch;

   genvar g;
   generate
      for (g = 0; g < NUM_CH; g++) begin : g_gate
         if (g == 0) begin : g_first
            assign gate[g] = brk_en[g] & ~seq_mode;
         end else begin : g_second
            assign gate[g] = brk_en[g] & (~seq_mode | flag0);
         end
      end
   endgenerate

   assign pre_ok  = cand_pre  & gate;
   assign post_ok = cand_post & gate;
   assign deliver = pend_v & ins_valid & ins_exec & ~ins_slot;
   assign fire    = (deliver | (|pre_ok)) & ~block_int;
   assign fire_ch = deliver ? pend_ch : ~pre_ok[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v  <= 1'b0;
         pend_ch <= 1'b0;
      end else if (|post_ok) begin
         pend_v  <= 1'b1;
         pend_ch <= ~post_ok[0];
      end else if (deliver) begin
         pend_v  <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         brk_req  <= 1'b0;
         brk_chan <= 1'b0;
         brk_addr <= '0;
      end else begin
         brk_req <= fire;
         if (fire) begin
            brk_chan <= fire_ch;
            brk_addr <= ins_addr;
         end
      end
   end

   AST_BLOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      block_int |=> !brk_req); // R8
   AST_OVERRUN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ins_valid && !ins_exec |=> !brk_req); // R5
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !ins_valid |=> !brk_req); // R3
   AST_SEQ_CH1_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      seq_mode && !pend_v |=> !brk_req || brk_chan); // R10

endmodule

// File: rtl/ibrk_unit.sv
module ibrk_unit
   import ibrk_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned REG_AW = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              ins_valid,
   input  logic [ADDR_W-1:0] ins_addr,
   input  logic              ins_exec,
   input  logic              ins_dbr,
   input  logic              ins_slot,
   input  logic [ADDR_W-1:0] ins_slot_addr,
   input  logic              block_int,
   output logic              brk_req,
   output logic              brk_chan,
   output logic [ADDR_W-1:0] brk_addr
);

   logic [ADDR_W-1:0] ch_addr [NUM_CH];
   ch_ctl_t           ch_ctl  [NUM_CH];
   logic [NUM_CH-1:0] hit, cand_pre, cand_post, brk_en;
   logic              seq_mode, flag0;

   ibrk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .match_set (hit),
      .ch_addr   (ch_addr),
      .ch_ctl    (ch_ctl),
      .seq_mode  (seq_mode),
      .flag0     (flag0)
   );

   genvar g;
   generate
      for (g = 0; g < NUM_CH; g++) begin : g_cmp
         ibrk_chan #(.ADDR_W(ADDR_W)) u_chan (
            .cfg_addr      (ch_addr[g]),
            .cfg_ctl       (ch_ctl[g]),
            .ins_valid     (ins_valid),
            .ins_exec      (ins_exec),
            .ins_dbr       (ins_dbr),
            .ins_slot      (ins_slot),
            .ins_addr      (ins_addr),
            .ins_slot_addr (ins_slot_addr),
            .hit           (hit[g]),
            .cand_pre      (cand_pre[g]),
            .cand_post     (cand_post[g])
         );
         assign brk_en[g] = ch_ctl[g].brk_en;
      end
   endgenerate

   ibrk_issue #(.ADDR_W(ADDR_W)) u_issue (
      .clk       (clk),
      .rst_n     (rst_n),
      .cand_pre  (cand_pre),
      .cand_post (cand_post),
      .brk_en    (brk_en),
      .seq_mode  (seq_mode),
      .flag0     (flag0),
      .block_int (block_int),
      .ins_valid (ins_valid),
      .ins_exec  (ins_exec),
      .ins_slot  (ins_slot),
      .ins_addr  (ins_addr),
      .brk_req   (brk_req),
      .brk_chan  (brk_chan),
      .brk_addr  (brk_addr)
   );

   AST_LSB_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      ch_addr[0][0] && ch_addr[1][0] && !brk_req |=> !brk_req); // R9

endmodule

// File: tb/ibrk_unit_tb.sv
`timescale 1ns/1ps
module ibrk_unit_tb;

   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [3:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          ins_valid = 1'b0;
   logic [AW-1:0] ins_addr = '0;
   logic          ins_exec = 1'b0;
   logic          ins_dbr = 1'b0;
   logic          ins_slot = 1'b0;
   logic [AW-1:0] ins_slot_addr = '0;
   logic          block_int = 1'b0;
   logic          brk_req;
   logic          brk_chan;
   logic [AW-1:0] brk_addr;

   always #10 clk = ~clk;

   ibrk_unit u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ins_valid(ins_valid),
      .ins_addr(ins_addr), .ins_exec(ins_exec), .ins_dbr(ins_dbr),
      .ins_slot(ins_slot), .ins_slot_addr(ins_slot_addr), .block_int(block_int),
      .brk_req(brk_req), .brk_chan(brk_chan), .brk_addr(brk_addr)
   );

   typedef struct {
      logic          fire;
      logic          chan;
      logic [AW-1:0] addr;
      string         tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done = 0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(posedge clk) begin
      #5;
      if (rst_n) begin
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            if (!e.fire)
               check(brk_req == 1'b0, e.tag, {31'd0, brk_req}, 32'd0);
            else begin
               check(brk_req == 1'b1, e.tag, {31'd0, brk_req}, 32'd1);
               check(brk_chan == e.chan && brk_addr == e.addr, e.tag,
                     {brk_chan, brk_addr[30:0]}, {e.chan, e.addr[30:0]});
            end
         end else if (brk_req) begin
            check(1'b0, "R3 unexpected request", brk_addr, 32'd0);
         end
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(reg_rdata == exp, tag, reg_rdata, exp);
   endtask

   task automatic beat(input logic [AW-1:0] a, input bit ex, input bit dbr,
                       input bit slot, input logic [AW-1:0] sa, input bit blk,
                       input bit fire, input bit ch, input logic [AW-1:0] ea,
                       input string tag);
      exp_t e;
      @(negedge clk);
      ins_valid = 1'b1; ins_addr = a; ins_exec = ex; ins_dbr = dbr;
      ins_slot = slot; ins_slot_addr = sa; block_int = blk;
      e.fire = fire; e.chan = ch; e.addr = ea; e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk);
      ins_valid = 1'b0; ins_dbr = 1'b0; ins_slot = 1'b0; block_int = 1'b0;
   endtask

   task automatic plain(input logic [AW-1:0] a, input bit fire, input bit ch,
                        input string tag);
      beat(a, 1, 0, 0, '0, 0, fire, ch, a, tag);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R14 reset state
      for (int i = 0; i < 9; i++) rd(4'(i), 32'd0, "R14 reset value");
      check(brk_req == 1'b0, "R14 reset brk_req", {31'd0, brk_req}, 32'd0);

      wr(0, 32'h1000); wr(1, 1); wr(2, 1);
      wr(3, 32'h2000); wr(4, 1); wr(5, 3);
      rd(0, 32'h1000, "R14 readback ch0 addr");
      rd(5, 32'h3,    "R14 readback ch1 op");

      // R1 / R3
      plain(32'h0FF0, 0, 0, "R1 no match");
      plain(32'h1001, 1, 0, "R3 pre break, R1 bit0 ignored");
      rd(6, 32'h100, "R1 flag0 set");

      // R11 clear, R5 overrun
      wr(6, 32'h300);
      rd(6, 32'h0, "R11 flags cleared");
      beat(32'h1000, 0, 0, 0, '0, 0, 0, 0, '0, "R5 overrun no break");
      rd(6, 32'h0, "R5 overrun no flag");

      // R2 enable
      wr(2, 0);
      plain(32'h1000, 0, 0, "R2 disabled no break");
      rd(6, 32'h100, "R2 flag still set");
      wr(2, 1);

      // R4 post
      plain(32'h2000, 0, 0, "R4 post not on match beat");
      plain(32'h2100, 1, 1, "R4 post delivered next");

      // R5 pending not delivered by overrun
      plain(32'h2000, 0, 0, "R5 post pending");
      beat(32'h2004, 0, 0, 0, '0, 0, 0, 0, '0, "R5 overrun skips delivery");
      plain(32'h5000, 1, 1, "R5 delivered after overrun");

      // R7 post on delayed branch
      beat(32'h2000, 1, 1, 0, 32'h2002, 0, 0, 0, '0, "R7 branch match");
      beat(32'h2002, 1, 0, 1, '0, 0, 0, 0, '0, "R7 slot skipped");
      plain(32'h3000, 1, 1, "R7 at target after branch");
      // R7 post on delay slot
      beat(32'h1FFC, 1, 1, 0, 32'h2000, 0, 0, 0, '0, "R7 branch owning slot");
      beat(32'h2000, 1, 0, 1, '0, 0, 0, 0, '0, "R7 slot match");
      plain(32'h4000, 1, 1, "R7 at target after slot");

      // R6 pre on slot
      beat(32'h0FFC, 1, 1, 0, 32'h1000, 0, 1, 0, 32'h0FFC, "R6 break before branch");
      beat(32'h1000, 1, 0, 1, '0, 0, 0, 0, '0, "R6 slot beat quiet");

      // R8 block
      wr(6, 32'h300);
      beat(32'h1000, 1, 0, 0, '0, 1, 0, 0, '0, "R8 blocked pre");
      rd(6, 32'h100, "R8 flag set while blocked");
      plain(32'h2000, 0, 0, "R8 post pending");
      beat(32'h6000, 1, 0, 0, '0, 1, 0, 0, '0, "R8 blocked delivery");
      plain(32'h6004, 0, 0, "R8 pending dropped");

      // R12 priority
      wr(3, 32'h1000); wr(5, 1);
      plain(32'h1000, 1, 0, "R12 ch0 wins tie");
      wr(3, 32'h2000); wr(5, 3);
      plain(32'h2000, 0, 0, "R12 post pending");
      plain(32'h1000, 1, 1, "R12 pending beats new pre");

      // R9 lsb
      wr(0, 32'h1001); wr(6, 32'h300);
      plain(32'h1000, 0, 0, "R9 lsb set no break");
      plain(32'h1001, 0, 0, "R9 lsb set no break odd");
      rd(6, 32'h0, "R9 no flag");
      wr(0, 32'h1000);

      // R13 data compare ignored
      wr(4, 3); wr(7, 32'hDEAD0000); wr(8, 32'hFFFFFFFF);
      wr(3, 32'h7000); wr(5, 1);
      plain(32'h7000, 1, 1, "R13 data regs ignored");
      rd(7, 32'hDEAD0000, "R14 data value readback");

      // R10 sequential
      wr(6, 32'h301);
      plain(32'h7000, 0, 0, "R10 ch1 before ch0 quiet");
      rd(6, 32'h201, "R10 ch1 flag set");
      plain(32'h1000, 0, 0, "R10 ch0 never requests");
      rd(6, 32'h301, "R10 ch0 flag set");
      plain(32'h7000, 1, 1, "R10 ch1 after ch0 breaks");
      // R11 release
      wr(6, 32'h101);
      rd(6, 32'h201, "R11 flag0 cleared");
      plain(32'h7000, 0, 0, "R11 sequence released");

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 32'd0);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule